// File: doc/BRIEF.md
# Shared-Pin Test-Access Mode Controller

This block lets a small group of device pins serve two masters. Normally the test clock, test data-in and test data-out pins belong to user logic as ordinary I/O. When the select pin is sampled low on a rising test-clock edge while the test state machine sits in its reset state, the block claims those pins for boundary-scan use. It keeps them until the state machine returns to its reset state, and then hands them back. A static fixed-test input chooses the plain standard behaviour instead, in which the pins are test pins permanently.

Inside is a complete sixteen-state test access port controller clocked by the test clock. Around it sit a small instruction register, a one-bit bypass register and a parameter-wide loop-back data register. These let the serial output path be exercised end to end. The serial output and its enable change on the falling test-clock edge. The output is driven only while a shift state is active. An active-low reset input returns everything to the reset state at once, with no clock edge needed.

Top module: `tap_pin_steer`

## Requirements
- R1: After `rstN` is released, `testOwnsPins` is 0, `serialOutEn` is 0 and `serialOut` is 0.
- R2: With `fixedTest` = 0, a rising `tstClk` edge that samples `modeSel` = 0 while the controller is in its reset state sets `testOwnsPins` to 1 right after that edge. Edges that sample `modeSel` = 1 in the reset state leave it at 0.
- R3: Once `testOwnsPins` is 1, it stays 1 on every edge that does not bring the controller to its reset state. Four consecutive edges with `modeSel` = 1 do not release it.
- R4: Five consecutive rising edges with `modeSel` = 1 bring the controller to its reset state from any state. With `fixedTest` = 0, `testOwnsPins` falls right after the edge that enters that state. If the next edge samples `modeSel` = 0, the pins are claimed again right after that edge.
- R5: Driving `rstN` low clears `testOwnsPins` and `serialOutEn` immediately, with no clock edge. The controller then restarts in its reset state.
- R6: While `fixedTest` = 1, `testOwnsPins` is 1 in every state, the reset state included.
- R7: `serialOutEn` is 1 only while the controller is in Shift-DR or Shift-IR. It and `serialOut` update only on falling `tstClk` edges, so they do not change at a rising edge.
- R8: Capture-IR loads the instruction shift stage with the value 1 (binary 01 for the default 2-bit width). Shift-IR shifts it out least significant bit first, with `serialIn` entering at the most significant end. Update-IR makes the shifted value the active instruction.
- R9: The all-ones instruction selects a 1-bit bypass register. It captures 0 in Capture-DR, so `serialOut` during Shift-DR is a leading 0 followed by `serialIn` delayed by one edge.
- R10: Any other instruction selects a DATA_W-bit loop register (8 bits by default, 0 after `rstN`). It keeps its contents through Capture-DR and shifts least significant bit first. The reset state forces the active instruction back to all ones (bypass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tstClk | input | 1 | Test clock; state moves on rising edges, serial output on falling edges |
| rstN | input | 1 | Asynchronous active-low reset of the controller and the registers |
| modeSel | input | 1 | Mode/state select sampled on rising `tstClk` |
| serialIn | input | 1 | Serial test data input |
| fixedTest | input | 1 | 1 = pins are permanently test pins; 0 = flexible sharing |
| testOwnsPins | output | 1 | 1 = shared pins act as test pins, 0 = user I/O |
| serialOut | output | 1 | Serial test data output |
| serialOutEn | output | 1 | Output enable for `serialOut` |

## Verification
Two functions can fall on the same rising edge: release of the pins on entering the reset state, and the next claim, which can follow on the very next edge. The bench gives five high select edges and checks that ownership drops right after the fifth. It then drives the select low on the following edge and expects ownership back right after that edge, with no idle cycle between. The asynchronous reset is also applied in the middle of a shift, while the output enable is high. Both outputs must clear before any further clock edge.

// File: rtl/tap_steer_pkg.sv
package tap_steer_pkg;

  typedef enum logic [3:0] {
    ST_TEST_RESET = 4'd0,
    ST_RUN_IDLE   = 4'd1,
    ST_SEL_DR     = 4'd2,
    ST_CAP_DR     = 4'd3,
    ST_SHIFT_DR   = 4'd4,
    ST_EXIT1_DR   = 4'd5,
    ST_PAUSE_DR   = 4'd6,
    ST_EXIT2_DR   = 4'd7,
    ST_UPD_DR     = 4'd8,
    ST_SEL_IR     = 4'd9,
    ST_CAP_IR     = 4'd10,
    ST_SHIFT_IR   = 4'd11,
    ST_EXIT1_IR   = 4'd12,
    ST_PAUSE_IR   = 4'd13,
    ST_EXIT2_IR   = 4'd14,
    ST_UPD_IR     = 4'd15
  } tapState_e;

  // Strobes from control to datapath, decoded from the current state.
  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
  } tapStrobe_t;

  function automatic tapState_e tapNext(input tapState_e s, input logic m);
    tapState_e n;
    case (s)
      ST_TEST_RESET: n = m ? ST_TEST_RESET : ST_RUN_IDLE;
      ST_RUN_IDLE:   n = m ? ST_SEL_DR     : ST_RUN_IDLE;
      ST_SEL_DR:     n = m ? ST_SEL_IR     : ST_CAP_DR;
      ST_CAP_DR:     n = m ? ST_EXIT1_DR   : ST_SHIFT_DR;
      ST_SHIFT_DR:   n = m ? ST_EXIT1_DR   : ST_SHIFT_DR;
      ST_EXIT1_DR:   n = m ? ST_UPD_DR     : ST_PAUSE_DR;
      ST_PAUSE_DR:   n = m ? ST_EXIT2_DR   : ST_PAUSE_DR;
      ST_EXIT2_DR:   n = m ? ST_UPD_DR     : ST_SHIFT_DR;
      ST_UPD_DR:     n = m ? ST_SEL_DR     : ST_RUN_IDLE;
      ST_SEL_IR:     n = m ? ST_TEST_RESET : ST_CAP_IR;
      ST_CAP_IR:     n = m ? ST_EXIT1_IR   : ST_SHIFT_IR;
      ST_SHIFT_IR:   n = m ? ST_EXIT1_IR   : ST_SHIFT_IR;
      ST_EXIT1_IR:   n = m ? ST_UPD_IR     : ST_PAUSE_IR;
      ST_PAUSE_IR:   n = m ? ST_EXIT2_IR   : ST_PAUSE_IR;
      ST_EXIT2_IR:   n = m ? ST_UPD_IR     : ST_SHIFT_IR;
      ST_UPD_IR:     n = m ? ST_SEL_DR     : ST_RUN_IDLE;
      default:       n = ST_TEST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_steer_ctrl.sv
module tap_steer_ctrl
  import tap_steer_pkg::*;
(
  input  logic       tstClk,
  input  logic       rstN,
  input  logic       modeSel,
  input  logic       fixedTest,
  output tapState_e  curState,
  output tapStrobe_t strobe,
  output logic       ownPins
);

  tapState_e nxtState;
  logic      claimed;

  always_comb nxtState = tapNext(curState, modeSel);

  // State register and pin-claim flag; both clear asynchronously.
  always_ff @(posedge tstClk or negedge rstN) begin
    if (!rstN) begin
      curState <= ST_TEST_RESET;
      claimed  <= 1'b0;
    end else begin
      curState <= nxtState;
      if (nxtState == ST_TEST_RESET)
        claimed <= 1'b0;
      else if (fixedTest || (curState == ST_TEST_RESET && !modeSel))
        claimed <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.inReset = (curState == ST_TEST_RESET);
    strobe.capIr   = (curState == ST_CAP_IR);
    strobe.shIr    = (curState == ST_SHIFT_IR);
    strobe.updIr   = (curState == ST_UPD_IR);
    strobe.capDr   = (curState == ST_CAP_DR);
    strobe.shDr    = (curState == ST_SHIFT_DR);
  end

  assign ownPins = fixedTest | claimed;

endmodule

// File: rtl/tap_steer_dpath.sv
module tap_steer_dpath
  import tap_steer_pkg::*;
#(
  parameter int IR_W   = 2,
  parameter int DATA_W = 8
) (
  input  logic       tstClk,
  input  logic       rstN,
  input  logic       serialIn,
  input  tapStrobe_t strobe,
  output logic       serialOut,
  output logic       serialOutEn
);

  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
  localparam logic [IR_W-1:0] IR_BYPASS  = '1;

  logic [IR_W-1:0]   irShift;
  logic [IR_W-1:0]   irActive;
  logic              bypassBit;
  logic [DATA_W-1:0] loopReg;
  logic [DATA_W-1:0] loopNext;
  logic              selBypass;
  logic              drOut;

  generate
    if (DATA_W == 1) begin : g_loopSingle
      assign loopNext = serialIn;
    end else begin : g_loopMulti
      assign loopNext = {serialIn, loopReg[DATA_W-1:1]};
    end
  endgenerate

  assign selBypass = (irActive == IR_BYPASS);
  assign drOut     = selBypass ? bypassBit : loopReg[0];

  // Instruction path: capture, shift, update; the reset state forces bypass.
  always_ff @(posedge tstClk or negedge rstN) begin
    if (!rstN) begin
      irShift  <= IR_CAPTURE;
      irActive <= IR_BYPASS;
    end else begin
      if (strobe.capIr)
        irShift <= IR_CAPTURE;
      else if (strobe.shIr)
        irShift <= {serialIn, irShift[IR_W-1:1]};
      if (strobe.inReset)
        irActive <= IR_BYPASS;
      else if (strobe.updIr)
        irActive <= irShift;
    end
  end

  // Data registers: bypass captures 0, loop register holds on capture.
  always_ff @(posedge tstClk or negedge rstN) begin
    if (!rstN) begin
      bypassBit <= 1'b0;
      loopReg   <= '0;
    end else begin
      if (selBypass) begin
        if (strobe.capDr)
          bypassBit <= 1'b0;
        else if (strobe.shDr)
          bypassBit <= serialIn;
      end else if (strobe.shDr) begin
        loopReg <= loopNext;
      end
    end
  end

  // Serial output moves on the falling edge.
  always_ff @(negedge tstClk or negedge rstN) begin
    if (!rstN) begin
      serialOut   <= 1'b0;
      serialOutEn <= 1'b0;
    end else begin
      serialOutEn <= strobe.shIr | strobe.shDr;
      if (strobe.shIr)
        serialOut <= irShift[0];
      else if (strobe.shDr)
        serialOut <= drOut;
    end
  end

endmodule

// File: rtl/tap_pin_steer.sv
module tap_pin_steer
  import tap_steer_pkg::*;
#(
  parameter int IR_W   = 2,
  parameter int DATA_W = 8
) (
  input  logic tstClk,
  input  logic rstN,
  input  logic modeSel,
  input  logic serialIn,
  input  logic fixedTest,
  output logic testOwnsPins,
  output logic serialOut,
  output logic serialOutEn
);

  tapState_e  tapNow;
  tapStrobe_t tapStb;

  tap_steer_ctrl u_ctrl (
    .tstClk   (tstClk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .fixedTest(fixedTest),
    .curState (tapNow),
    .strobe   (tapStb),
    .ownPins  (testOwnsPins)
  );

  tap_steer_dpath #(
    .IR_W  (IR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .tstClk     (tstClk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .strobe     (tapStb),
    .serialOut  (serialOut),
    .serialOutEn(serialOutEn)
  );

endmodule

// File: rtl/tap_pin_steer_chk.sv
module tap_pin_steer_chk
  import tap_steer_pkg::*;
(
  input logic      tstClk,
  input logic      rstN,
  input logic      modeSel,
  input logic      fixedTest,
  input logic      ownPins,
  input logic      outEn,
  input tapState_e st
);

  logic [2:0] hiCnt;

  always_ff @(posedge tstClk or negedge rstN) begin
    if (!rstN)
      hiCnt <= 3'd0;
    else if (!modeSel)
      hiCnt <= 3'd0;
    else if (hiCnt != 3'd5)
      hiCnt <= hiCnt + 3'd1;
  end

  // R2
  enter_test_chk: assert property (@(posedge tstClk) disable iff (!rstN)
    (st == ST_TEST_RESET && !modeSel) |=> ownPins);

  // R3
  hold_test_chk: assert property (@(posedge tstClk) disable iff (!rstN)
    ownPins |=> (ownPins || st == ST_TEST_RESET));

  // R4
  release_chk: assert property (@(posedge tstClk) disable iff (!rstN)
    (st == ST_TEST_RESET && !fixedTest) |-> !ownPins);

  // R4
  five_high_chk: assert property (@(posedge tstClk) disable iff (!rstN)
    (hiCnt == 3'd5) |-> (st == ST_TEST_RESET));

  // R6
  fixed_test_chk: assert property (@(posedge tstClk) disable iff (!rstN)
    fixedTest |-> ownPins);

  // R7
  out_en_chk: assert property (@(posedge tstClk) disable iff (!rstN)
    outEn |-> (st == ST_SHIFT_IR || st == ST_SHIFT_DR));

endmodule

bind tap_pin_steer tap_pin_steer_chk u_chk (
  .tstClk   (tstClk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .fixedTest(fixedTest),
  .ownPins  (testOwnsPins),
  .outEn    (serialOutEn),
  .st       (tapNow)
);

// File: tb/tap_pin_steer_tb.sv
module tap_pin_steer_tb;

  localparam int CLK_PERIOD = 10;

  logic tstClk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b1;
  logic serialIn = 1'b0;
  logic fixedTest = 1'b0;
  logic testOwnsPins;
  logic serialOut;
  logic serialOutEn;

  int checks = 0;
  int errors = 0;
  logic lastOut;
  logic lastEn;

  tap_pin_steer u_dut (
    .tstClk      (tstClk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .serialIn    (serialIn),
    .fixedTest   (fixedTest),
    .testOwnsPins(testOwnsPins),
    .serialOut   (serialOut),
    .serialOutEn (serialOutEn)
  );

  always #(CLK_PERIOD / 2) tstClk = ~tstClk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Output is sampled at the falling edge, inputs driven there, then one rising edge.
  task automatic tick(input logic m, input logic d);
    @(negedge tstClk);
    #1;
    lastOut  = serialOut;
    lastEn   = serialOutEn;
    modeSel  = m;
    serialIn = d;
    @(posedge tstClk);
    #1;
  endtask

  task automatic shiftBits(input int n, input logic [15:0] din,
                           output logic [15:0] dout, output int enCount);
    dout = '0;
    enCount = 0;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = lastOut;
      if (lastEn) enCount++;
    end
  endtask

  task automatic fiveHigh();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
  endtask

  task automatic toShiftDr();  // from Run-Test/Idle
    tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic toShiftIr();  // from Run-Test/Idle
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic exitToIdle();  // from Exit1 through Update to Run-Test/Idle
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [1:0] code);
    logic [15:0] o;
    int e;
    toShiftIr();
    shiftBits(2, {14'd0, code}, o, e);
    exitToIdle();
  endtask

  task automatic testReset();
    #(CLK_PERIOD * 2 + 2);
    rstN = 1'b1;
    #(CLK_PERIOD * 2);
    chk("R1 ownership after reset", int'(testOwnsPins), 0);
    chk("R1 enable after reset", int'(serialOutEn), 0);
    chk("R1 data after reset", int'(serialOut), 0);
  endtask

  task automatic testClaimRelease();
    tick(1'b1, 1'b0);
    chk("R2 high select keeps user mode", int'(testOwnsPins), 0);
    tick(1'b0, 1'b0);
    chk("R2 low select claims pins", int'(testOwnsPins), 1);
    toShiftDr();
    for (int i = 0; i < 4; i++) begin
      tick(1'b1, 1'b0);
      chk("R3 four highs keep test mode", int'(testOwnsPins), 1);
    end
    tick(1'b1, 1'b0);
    chk("R4 fifth high releases pins", int'(testOwnsPins), 0);
    tick(1'b0, 1'b0);
    chk("R4 reclaim on edge right after release", int'(testOwnsPins), 1);
    // from Pause-IR
    tick(1'b1, 1'b0); tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    tick(1'b1, 1'b0); tick(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0);
    chk("R3 still test after four highs from pause", int'(testOwnsPins), 1);
    tick(1'b1, 1'b0);
    chk("R4 release from pause state", int'(testOwnsPins), 0);
  endtask

  task automatic testIrCapture();
    logic [15:0] o;
    int e;
    tick(1'b0, 1'b0);
    toShiftIr();
    shiftBits(2, 16'h0000, o, e);
    chk("R8 captured instruction shifted out", int'(o[1:0]), 1);
    chk("R7 enable during shift", e, 2);
    chk("R7 output held across rising edge", int'(serialOut), int'(o[1]));
    tick(1'b1, 1'b0);
    chk("R7 enable low outside shift", int'(lastEn), 0);
    tick(1'b0, 1'b0);
  endtask

  task automatic testLoop();
    logic [15:0] o;
    int e;
    toShiftDr();
    shiftBits(8, 16'h00A5, o, e);
    chk("R10 loop register initial content", int'(o[7:0]), 0);
    exitToIdle();
    toShiftDr();
    shiftBits(8, 16'h003C, o, e);
    chk("R10 loop register returns previous shift", int'(o[7:0]), 'hA5);
    chk("R7 enable count in data shift", e, 8);
    exitToIdle();
  endtask

  task automatic testBypass();
    logic [15:0] o;
    int e;
    loadIr(2'b11);
    toShiftDr();
    shiftBits(8, 16'h00A5, o, e);
    chk("R9 bypass delays by one with leading 0", int'(o[7:0]), 'h4A);
    exitToIdle();
    loadIr(2'b00);
    fiveHigh();
    tick(1'b0, 1'b0);
    toShiftDr();
    shiftBits(8, 16'h00FF, o, e);
    chk("R10 reset state restores bypass", int'(o[7:0]), 'hFE);
    exitToIdle();
  endtask

  task automatic testAsync();
    toShiftDr();
    @(negedge tstClk);
    #2;
    chk("R5 enable high before reset", int'(serialOutEn), 1);
    modeSel = 1'b1;
    rstN = 1'b0;
    #1;
    chk("R5 ownership cleared without clock", int'(testOwnsPins), 0);
    chk("R5 enable cleared without clock", int'(serialOutEn), 0);
    #1;
    rstN = 1'b1;
    tick(1'b1, 1'b0);
    chk("R5 restarts in reset state", int'(testOwnsPins), 0);
  endtask

  task automatic testFixed();
    fixedTest = 1'b1;
    #1;
    chk("R6 fixed mode owns pins in reset state", int'(testOwnsPins), 1);
    tick(1'b0, 1'b0);
    fiveHigh();
    chk("R6 fixed mode keeps pins after five highs", int'(testOwnsPins), 1);
    tick(1'b1, 1'b0);
    chk("R7 no enable in reset state", int'(lastEn), 0);
    fixedTest = 1'b0;
    #1;
    chk("R6 leaving fixed mode in reset state", int'(testOwnsPins), 0);
  endtask

  initial begin
    testReset();
    testClaimRelease();
    testIrCapture();
    testLoop();
    testBypass();
    testAsync();
    testFixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tstClk);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule